// File: doc/BRIEF.md
# CCM Formatting and Counter Block Generator

This block produces the two kinds of 128-bit input blocks that a CCM authenticated-encryption engine feeds to its block cipher: the initial authentication block (B0) and the keystream counter blocks (CTR0, CTR1, ...). Each block leaves the block as a stream of 16 bytes, one per clock, so that a byte-serial cipher core can take it directly.

The nonce arrives one byte per load strobe and sits in a byte-wide shift register. While a block is streamed, that register rotates one place per nonce byte sent, so after every block it holds the nonce exactly as loaded and any number of further blocks can be built without reloading. A message starts with a clear pulse that sets the counter index back to zero. Each counter block carries the current index and advances it by one when it finishes. The initial block carries the payload length, sampled when it is requested.

Each block has a flags byte, then the nonce, then a big-endian field. In the initial block the field is the payload length; in a counter block it is the index. The widths come from parameters: nonce bytes, field bytes and tag bytes. The flags byte of the initial block encodes a tag size and a field size and marks the message as having no associated data.

Top module: `ccm_block_former`

## Requirements
- R1: After reset, blk_valid and busy are 0 and the counter index is 0, so the first counter block after reset carries the field value 0x0000.
- R2: While the block is idle, each cycle with nonce_load high shifts nonce_byte in. Once at least 13 bytes are loaded, block bytes 1 to 13 are the last 13 bytes loaded, the oldest at byte 1.
- R3: Byte 0 of an initial block is 0x09 (bit 6 = 0 for no associated data, bits 5:3 = (tag bytes-2)/2 = 1, bits 2:0 = field bytes-1 = 1).
- R4: Bytes 14 and 15 of an initial block hold the plen value sampled in the request cycle, most significant byte at byte 14.
- R5: Byte 0 of a counter block is 0x01 (field bytes-1). Bytes 14 and 15 hold the current index i, most significant byte at byte 14.
- R6: When a counter block finishes, the index increases by one. An initial block leaves it unchanged.
- R7: A msg_start pulse while idle sets the index to 0 before the next counter block.
- R8: A block is streamed in the 16 cycles after the request edge, with blk_valid and busy high on all 16. blk_last is high only on byte 15, and blk_valid is low in the cycle after it.
- R9: If req_b0 and req_ctr are high in the same idle cycle, an initial block is produced.
- R10: While busy, req_b0, req_ctr, msg_start, nonce_load and plen are ignored. The nonce is unchanged after every block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| nonce_byte | input | 8 | Nonce byte to shift in |
| nonce_load | input | 1 | Strobe: shift nonce_byte into the nonce register |
| msg_start | input | 1 | Start of message: clear the counter index |
| plen | input | 16 | Payload length in bytes for the initial block |
| req_b0 | input | 1 | Request an initial block |
| req_ctr | input | 1 | Request the next counter block |
| blk_byte | output | 8 | Current block byte |
| blk_valid | output | 1 | blk_byte is a block byte |
| blk_last | output | 1 | Final byte of the block |
| busy | output | 1 | A block is being streamed |

## Verification
The bench uses the default parameters: a 13-byte nonce, a 2-byte field and a 4-byte tag. With these values the flags bytes are 0x09 and 0x01, and the field boundary falls between bytes 13 and 14, where the streamed bytes change from nonce to field. Several counter blocks run back to back, so the bench sees the nonce come back intact through repeated full rotations. It also sees the index run through several values and be cleared in the middle of a sequence. Both field bytes are exercised: a length of 0x1234 shows the byte order, and a length change that arrives mid-block shows that the length is sampled at the request.

// File: rtl/ccm_fmt_pkg.sv
package ccm_fmt_pkg;
  // flags byte of the initial block: no associated data, tag and field sizes
  function automatic logic [7:0] flags_init(input int tag_bytes, input int fld_bytes);
    logic [2:0] t_code;
    logic [2:0] q_code;
    t_code = 3'((tag_bytes - 2) / 2);
    q_code = 3'(fld_bytes - 1);
    return {2'b00, t_code, q_code};
  endfunction

  // flags byte of a counter block: field size only
  function automatic logic [7:0] flags_ctr(input int fld_bytes);
    return {5'b00000, 3'(fld_bytes - 1)};
  endfunction
endpackage

// File: rtl/ccm_nonce_store.sv
module ccm_nonce_store #(
  parameter int NB = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_en,
  input  logic [7:0] load_byte,
  input  logic       rot_en,
  output logic [7:0] head
);
  logic [7:0] cell_q [NB];
  logic [7:0] cell_d [NB];
  logic       upd;

  assign upd = load_en | rot_en;

  generate
    for (genvar j = 0; j < NB; j++) begin : g_cell
      if (j == NB - 1) begin : g_tail
        always_comb cell_d[j] = load_en ? load_byte : cell_q[0];
      end else begin : g_body
        always_comb cell_d[j] = cell_q[j+1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cell_q[j] <= '0;
        else if (upd) cell_q[j] <= cell_d[j];
      end
    end
  endgenerate

  assign head = cell_q[0];
endmodule

// File: rtl/ccm_block_seq.sv
module ccm_block_seq #(
  parameter int BLK   = 16,
  parameter int NB    = 13,
  parameter int CW    = 16,
  localparam int POS_W = $clog2(BLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_b0,
  input  logic             req_ctr,
  input  logic             msg_start,
  input  logic [CW-1:0]    plen_in,
  output logic             busy,
  output logic             is_init,
  output logic [POS_W-1:0] pos,
  output logic             last,
  output logic             rot_en,
  output logic [CW-1:0]    field
);
  logic             busy_q, busy_d;
  logic             init_q, init_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [CW-1:0]    plen_q, plen_d;
  logic [CW-1:0]    idx_q, idx_d;
  logic             at_end;

  assign at_end = busy_q && (pos_q == POS_W'(BLK - 1));

  always_comb begin
    busy_d = busy_q;
    init_d = init_q;
    pos_d  = pos_q;
    plen_d = plen_q;
    idx_d  = idx_q;
    if (busy_q) begin
      pos_d = pos_q + POS_W'(1);
      if (at_end) begin
        busy_d = 1'b0;
        pos_d  = '0;
        if (!init_q) idx_d = idx_q + CW'(1);
      end
    end else begin
      if (msg_start) idx_d = '0;
      if (req_b0 || req_ctr) begin
        busy_d = 1'b1;
        pos_d  = '0;
        init_d = req_b0;
        if (req_b0) plen_d = plen_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      init_q <= 1'b0;
      pos_q  <= '0;
      plen_q <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      init_q <= init_d;
      pos_q  <= pos_d;
      plen_q <= plen_d;
      idx_q  <= idx_d;
    end
  end

  assign busy    = busy_q;
  assign is_init = init_q;
  assign pos     = pos_q;
  assign last    = at_end;
  assign rot_en  = busy_q && (pos_q != '0) && (int'(pos_q) <= NB);
  assign field   = init_q ? plen_q : idx_q;

  p_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !at_end) |=> busy_q);
  p_last_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |=> !busy_q);
  p_idx_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !init_q) |=> idx_q == $past(idx_q) + CW'(1));
  p_idx_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && init_q) |=> $stable(idx_q));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_start && !busy_q) |=> idx_q == '0);
endmodule

// File: rtl/ccm_block_former.sv
module ccm_block_former #(
  parameter int NONCE_BYTES = 13,
  parameter int FIELD_BYTES = 2,
  parameter int TAG_BYTES   = 4,
  localparam int BLK   = 1 + NONCE_BYTES + FIELD_BYTES,
  localparam int CW    = 8 * FIELD_BYTES,
  localparam int POS_W = $clog2(BLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    nonce_byte,
  input  logic          nonce_load,
  input  logic          msg_start,
  input  logic [CW-1:0] plen,
  input  logic          req_b0,
  input  logic          req_ctr,
  output logic [7:0]    blk_byte,
  output logic          blk_valid,
  output logic          blk_last,
  output logic          busy
);
  import ccm_fmt_pkg::*;

  localparam logic [7:0] FLG_INIT = flags_init(TAG_BYTES, FIELD_BYTES);
  localparam logic [7:0] FLG_CTR  = flags_ctr(FIELD_BYTES);

  logic             rs_a, rs_b;
  logic             busy_w, init_w, last_w, rot_w;
  logic [POS_W-1:0] pos_w;
  logic [CW-1:0]    field_w;
  logic [7:0]       head_w;

  // reset: asserted at once, released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end

  ccm_block_seq #(.BLK(BLK), .NB(NONCE_BYTES), .CW(CW)) u_seq (
    .clk      (clk),
    .rst_n    (rs_b),
    .req_b0   (req_b0),
    .req_ctr  (req_ctr),
    .msg_start(msg_start),
    .plen_in  (plen),
    .busy     (busy_w),
    .is_init  (init_w),
    .pos      (pos_w),
    .last     (last_w),
    .rot_en   (rot_w),
    .field    (field_w)
  );

  ccm_nonce_store #(.NB(NONCE_BYTES)) u_nonce (
    .clk      (clk),
    .rst_n    (rs_b),
    .load_en  (nonce_load && !busy_w),
    .load_byte(nonce_byte),
    .rot_en   (rot_w),
    .head     (head_w)
  );

  always_comb begin
    blk_byte = '0;
    if (pos_w == '0) begin
      blk_byte = init_w ? FLG_INIT : FLG_CTR;
    end else if (int'(pos_w) <= NONCE_BYTES) begin
      blk_byte = head_w;
    end else begin
      for (int j = 0; j < FIELD_BYTES; j++)
        if (int'(pos_w) == NONCE_BYTES + 1 + j)
          blk_byte = field_w[8*(FIELD_BYTES-1-j) +: 8];
    end
  end

  assign blk_valid = busy_w;
  assign blk_last  = last_w;
  assign busy      = busy_w;

  p_flags_r3: assert property (@(posedge clk) disable iff (!rs_b)
    $rose(blk_valid) |-> (blk_byte == FLG_INIT || blk_byte == FLG_CTR));
  p_last_valid_r8: assert property (@(posedge clk) disable iff (!rs_b)
    blk_last |-> blk_valid);
endmodule

// File: tb/test_ccm_block_former.sv
module test_ccm_block_former;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  nonce_byte;
  logic        nonce_load, msg_start, req_b0, req_ctr;
  logic [15:0] plen;
  logic [7:0]  blk_byte;
  logic        blk_valid, blk_last, busy;

  int n_run = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0]  nonce_m [13];
  logic [15:0] idx_m;
  logic [7:0]  got [16];
  int          tmg_bad;

  always #10 clk = ~clk;

  ccm_block_former i_ccm_block_former (
    .clk(clk), .rst_n(rst_n), .nonce_byte(nonce_byte), .nonce_load(nonce_load),
    .msg_start(msg_start), .plen(plen), .req_b0(req_b0), .req_ctr(req_ctr),
    .blk_byte(blk_byte), .blk_valid(blk_valid), .blk_last(blk_last), .busy(busy)
  );

  // op: 0 = initial block, 1 = counter block, 2 = message start pulse
  localparam logic [17:0] VEC [9] = '{
    {2'd1, 16'h0000}, {2'd0, 16'h0020}, {2'd1, 16'h0000}, {2'd1, 16'h0000},
    {2'd2, 16'h0000}, {2'd1, 16'h0000}, {2'd0, 16'h1234}, {2'd1, 16'h0000},
    {2'd1, 16'h0000}
  };

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input bit init, input logic [15:0] fld);
    logic [127:0] v;
    v[127:120] = init ? 8'h09 : 8'h01;
    for (int k = 0; k < 13; k++) v[119-8*k -: 8] = nonce_m[k];
    v[15:0] = fld;
    return v;
  endfunction

  function automatic logic [127:0] packed_got();
    logic [127:0] v;
    for (int k = 0; k < 16; k++) v[127-8*k -: 8] = got[k];
    return v;
  endfunction

  task automatic load_nonce(input logic [7:0] first, input int cnt);
    for (int k = 0; k < cnt; k++) begin
      nonce_byte = first + 8'(k);
      nonce_load = 1'b1;
      @(negedge clk);
      for (int m = 0; m < 12; m++) nonce_m[m] = nonce_m[m+1];
      nonce_m[12] = first + 8'(k);
    end
    nonce_load = 1'b0;
  endtask

  // runs one request; disturb drives every input hard in the middle of the block
  task automatic run_blk(input bit rb, input bit rc, input logic [15:0] pl,
                         input bit disturb);
    tmg_bad = 0;
    req_b0 = rb; req_ctr = rc; plen = pl;
    @(negedge clk);
    req_b0 = 1'b0; req_ctr = 1'b0;
    for (int k = 0; k < 16; k++) begin
      got[k] = blk_byte;
      if (blk_valid !== 1'b1 || busy !== 1'b1) tmg_bad++;
      if (blk_last !== (k == 15)) tmg_bad++;
      if (disturb && k == 5) begin
        req_b0 = 1'b1; req_ctr = 1'b1; msg_start = 1'b1;
        nonce_load = 1'b1; nonce_byte = 8'hEE; plen = 16'hBEEF;
      end
      if (disturb && k == 6) begin
        req_b0 = 1'b0; req_ctr = 1'b0; msg_start = 1'b0;
        nonce_load = 1'b0;
      end
      @(negedge clk);
    end
    if (blk_valid !== 1'b0) tmg_bad++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] pl_keep;
    rst_n = 1'b0; nonce_byte = '0; nonce_load = 0; msg_start = 0;
    req_b0 = 0; req_ctr = 0; plen = '0;
    for (int m = 0; m < 13; m++) nonce_m[m] = 8'h00;
    idx_m = '0;
    repeat (3) @(negedge clk);
    chk(blk_valid === 1'b0 && busy === 1'b0, "R1 reset outputs",
        {126'b0, blk_valid, busy}, 128'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    load_nonce(8'h10, 13);   // R2 nonce bytes 0x10..0x1c

    // vector walk: R1, R3, R4, R5, R6, R7, R8
    foreach (VEC[v]) begin
      if (VEC[v][17:16] == 2'd2) begin
        msg_start = 1'b1; @(negedge clk); msg_start = 1'b0;
        idx_m = '0;
      end else begin
        bit is_i;
        is_i = (VEC[v][17:16] == 2'd0);
        run_blk(is_i, !is_i, VEC[v][15:0], 1'b0);
        chk(packed_got() === model(is_i, is_i ? VEC[v][15:0] : idx_m),
            is_i ? "R3 R4 initial block" : "R5 R6 R7 counter block",
            packed_got(), model(is_i, is_i ? VEC[v][15:0] : idx_m));
        chk(tmg_bad == 0, "R8 valid/last framing", 128'(tmg_bad), 128'h0);
        if (!is_i) idx_m = idx_m + 16'd1;
      end
    end

    // R9: both requests at once -> initial block, index unchanged
    run_blk(1'b1, 1'b1, 16'h00A5, 1'b0);
    chk(packed_got() === model(1'b1, 16'h00A5), "R9 priority", packed_got(),
        model(1'b1, 16'h00A5));

    // R10: inputs ignored while busy; plen sampled at request
    pl_keep = 16'h0102;
    run_blk(1'b1, 1'b0, pl_keep, 1'b1);
    chk(packed_got() === model(1'b1, pl_keep), "R10 R4 plen sampled", packed_got(),
        model(1'b1, pl_keep));
    chk(tmg_bad == 0, "R10 no restart", 128'(tmg_bad), 128'h0);
    run_blk(1'b0, 1'b1, 16'h0, 1'b0);
    chk(packed_got() === model(1'b0, idx_m), "R10 R6 index and nonce kept",
        packed_got(), model(1'b0, idx_m));
    idx_m = idx_m + 16'd1;

    // R2: 14 loads keep the last 13
    load_nonce(8'hA0, 14);
    msg_start = 1'b1; @(negedge clk); msg_start = 1'b0; idx_m = '0;
    run_blk(1'b0, 1'b1, 16'h0, 1'b0);
    chk(packed_got() === model(1'b0, 16'h0000), "R2 R7 reloaded nonce",
        packed_got(), model(1'b0, 16'h0000));
    chk(nonce_m[0] === 8'hA1, "R2 oldest byte", {120'b0, got[1]}, 128'hA1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule